// File: doc/BRIEF.md
# Signed Four-Bit ALU with One-Hot Operation Select

This block is a purely combinational arithmetic/logic unit for small signed two's complement operands. Two operands enter and one result word leaves, together with an equality status bit and an overflow flag. Three one-hot select lines choose between the adder path, the bitwise NAND path and the signed less-than path. A separate carry-in line turns the adder into a subtractor by feeding the inverted second operand into the same ripple chain, so subtraction has no select line of its own.

The adder is a ripple chain of one-bit full adders. The less-than path always subtracts through that chain, whatever the carry-in line says. When the operand signs differ, the answer comes straight from the sign bits, so the result is correct even where the subtraction would overflow. Overflow is taken from the disagreement between the carry into and the carry out of the top full adder. The operand width is a parameter with a default of 4.

Top module: `sgn_alu`

## Requirements
- R1: With `sel_add` high and `sub_cin` low, `result` equals (A + B) modulo 2^W.
- R2: With `sel_add` high and `sub_cin` high, `result` equals (A - B) modulo 2^W.
- R3: With `sel_add` high, `ovf` is 1 exactly when the signed sum (R1) or signed difference (R2) lies outside the range -2^(W-1) to 2^(W-1)-1.
- R4: With `sel_nand` high, `result` equals the bitwise complement of (A AND B).
- R5: With `sel_lt` high, `result` is 1 (only bit 0 set) when A is less than B as signed values, and 0 otherwise, for every operand pair and for either value of `sub_cin`.
- R6: `equal` is 1 exactly when A equals B, whichever select line is high or none.
- R7: `ovf` is 0 whenever `sel_add` is low.
- R8: With no select line high, `result` is all zeros for any operands and any `sub_cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First signed operand |
| opnd_b | input | W | Second signed operand |
| sub_cin | input | 1 | Carry-in to the ripple chain; high with `sel_add` means subtract |
| sel_add | input | 1 | One-hot select: add or subtract |
| sel_nand | input | 1 | One-hot select: bitwise NAND |
| sel_lt | input | 1 | One-hot select: signed less-than |
| result | output | W | Result word |
| equal | output | 1 | High when the operands are equal |
| ovf | output | 1 | Signed overflow of the add or subtract |

## Verification
The bench builds the block with W = 4, the default. At that width all 256 operand pairs can be driven through every select setting, including less-than with the carry-in both low and high and the idle case with no select. The sweep therefore covers every overflow boundary, such as subtracting the most negative value, and every pair with opposite signs whose difference wraps. Seeded random vectors and directed pairs at -8 and 7 are added to this sweep.

// File: rtl/sgn_alu_pkg.sv
package sgn_alu_pkg;
  typedef struct packed {
    logic do_add;
    logic do_nand;
    logic do_lt;
  } alu_sel_t;

  function automatic logic sel_idle(input alu_sel_t s);
    return ~(s.do_add | s.do_nand | s.do_lt);
  endfunction
endpackage

// File: rtl/sgn_alu_fa.sv
module sgn_alu_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;
  assign half = a ^ b;
  assign s    = half ^ ci;
  assign co   = (a & b) | (half & ci);
endmodule

// File: rtl/sgn_alu_ripple.sv
module sgn_alu_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_msb_in,
  output logic         c_out
);
  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    sgn_alu_fa u_fa (
      .a (a[i]),
      .b (b[i]),
      .ci(carry[i]),
      .s (sum[i]),
      .co(carry[i+1])
    );
  end

  assign c_msb_in = carry[W-1];
  assign c_out    = carry[W];
endmodule

// File: rtl/sgn_alu_cmp.sv
module sgn_alu_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         diff_sign,
  output logic         less,
  output logic         same
);
  logic signs_differ;
  assign signs_differ = a[W-1] ^ b[W-1];
  // Opposite signs: the negative operand is the smaller one.
  assign less = signs_differ ? a[W-1] : diff_sign;
  assign same = ~|(a ^ b);
endmodule

// File: rtl/sgn_alu.sv
module sgn_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         sub_cin,
  input  logic         sel_add,
  input  logic         sel_nand,
  input  logic         sel_lt,
  output logic [W-1:0] result,
  output logic         equal,
  output logic         ovf
);
  import sgn_alu_pkg::*;

  localparam logic [W-1:0] ZERO_W = '0;

  alu_sel_t       sel;
  logic           cin_eff;
  logic [W-1:0]   b_chain;
  logic [W-1:0]   sum;
  logic           c_msb_in;
  logic           c_out;
  logic           less;
  logic [W-1:0]   lt_word;
  logic [W-1:0]   nand_word;

  assign sel     = '{do_add: sel_add, do_nand: sel_nand, do_lt: sel_lt};
  assign cin_eff = sub_cin | sel.do_lt;
  assign b_chain = opnd_b ^ {W{cin_eff}};

  sgn_alu_ripple #(.W(W)) u_chain (
    .a       (opnd_a),
    .b       (b_chain),
    .cin     (cin_eff),
    .sum     (sum),
    .c_msb_in(c_msb_in),
    .c_out   (c_out)
  );

  sgn_alu_cmp #(.W(W)) u_cmp (
    .a        (opnd_a),
    .b        (opnd_b),
    .diff_sign(sum[W-1]),
    .less     (less),
    .same     (equal)
  );

  assign nand_word = ~(opnd_a & opnd_b);
  assign lt_word   = {ZERO_W[W-1:1], less};

  always_comb begin
    result = ZERO_W;
    if (!sel_idle(sel)) begin
      if (sel.do_add)  result = result | sum;
      if (sel.do_nand) result = result | nand_word;
      if (sel.do_lt)   result = result | lt_word;
    end
  end

  assign ovf = sel.do_add & (c_msb_in ^ c_out);
endmodule

// File: rtl/sgn_alu_chk.sv
module sgn_alu_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         sub_cin,
  input logic         sel_add,
  input logic         sel_nand,
  input logic         sel_lt,
  input logic [W-1:0] result,
  input logic         equal,
  input logic         ovf
);
  logic unused_cin;
  assign unused_cin = sub_cin;

  always_comb begin
    p_equal_status_r6: assert (equal == (opnd_a == opnd_b));
    if (!sel_add)
      p_no_overflow_r7: assert (!ovf);
    if (!sel_add && !sel_nand && !sel_lt)
      p_idle_zero_r8: assert (result == '0);
    if (sel_nand && !sel_add && !sel_lt)
      p_nand_word_r4: assert (result == ~(opnd_a & opnd_b));
    if (sel_lt && !sel_add && !sel_nand)
      p_less_signed_r5: assert (result ==
        {{(W-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))});
  end
endmodule

bind sgn_alu sgn_alu_chk #(.W(W)) u_chk (
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .sub_cin (sub_cin),
  .sel_add (sel_add),
  .sel_nand(sel_nand),
  .sel_lt  (sel_lt),
  .result  (result),
  .equal   (equal),
  .ovf     (ovf)
);

// File: tb/sgn_alu_tb.sv
`timescale 1ns/1ps
module sgn_alu_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic         sub_cin = 1'b0, sel_add = 1'b0, sel_nand = 1'b0, sel_lt = 1'b0;
  logic [W-1:0] result;
  logic         equal, ovf;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  sgn_alu #(.W(W)) u_dut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sub_cin(sub_cin),
    .sel_add(sel_add), .sel_nand(sel_nand), .sel_lt(sel_lt),
    .result(result), .equal(equal), .ovf(ovf)
  );

  function automatic int sval(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d op=%b%b%b cin=%b actual=%0d expected=%0d",
               req, opnd_a, opnd_b, sel_add, sel_nand, sel_lt, sub_cin, act, exp);
    end
  endtask

  // op: 0 add, 1 sub, 2 nand, 3 lt cin=0, 4 lt cin=1, 5 idle cin=1
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input int op);
    int sa, sb, r;
    int exp_res, exp_ovf;
    string rq;
    @(posedge clk);
    opnd_a = a; opnd_b = b;
    sel_add  = (op == 0 || op == 1);
    sel_nand = (op == 2);
    sel_lt   = (op == 3 || op == 4);
    sub_cin  = (op == 1 || op == 4 || op == 5);
    sa = sval(a); sb = sval(b);
    exp_ovf = 0;
    case (op)
      0: begin r = sa + sb; rq = "R1"; end
      1: begin r = sa - sb; rq = "R2"; end
      2: begin r = ~(int'(a) & int'(b)); rq = "R4"; end
      3, 4: begin r = (sa < sb) ? 1 : 0; rq = "R5"; end
      default: begin r = 0; rq = "R8"; end
    endcase
    if (op <= 1) exp_ovf = (r > (1 << (W-1)) - 1 || r < -(1 << (W-1))) ? 1 : 0;
    exp_res = r & ((1 << W) - 1);
    @(negedge clk);
    check(rq, int'(result), exp_res);
    check((op <= 1) ? "R3" : "R7", int'(ovf), exp_ovf);
    check("R6", int'(equal), (a == b) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8", int'(result), 0);   // reset/idle state: no select driven
    check("R7", int'(ovf), 0);
    // directed corners: -8 and 7 extremes
    apply(4'h7, 4'h1, 0);           // R3 positive overflow
    apply(4'h8, 4'hF, 0);           // R3 negative overflow
    apply(4'h0, 4'h8, 1);           // R2/R3 subtract most negative
    apply(4'h9, 4'h7, 3);           // R5 -7 < 7
    apply(4'h7, 4'h9, 4);           // R5 7 < -7 false, cin high
    apply(4'h5, 4'h5, 5);           // R8 idle
    // exhaustive sweep
    for (int op = 0; op < 6; op++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          apply(W'(a), W'(b), op);
    // seeded random
    void'($urandom(32'd20250));
    for (int i = 0; i < 400; i++)
      apply(W'($urandom), W'($urandom), int'($urandom % 6));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule